// File: doc/BRIEF.md
# Mode-Protected Pin Function Control Register

This block holds an 8-bit control register that chooses, pin by pin, whether six pins of a general-purpose port carry bus-control signals or stay under the port's ordinary GPIO path. Five register fields control them. One field covers the CPU free-cycle flag. One covers the two instruction-queue status pins. One disables the external bus clock output. One covers the low-byte strobe and one the read/write line. The register's write access and the fields' effect both depend on the chip's 3-bit operating mode.

Normal modes allow one write to the bus-function fields after reset, while the clock-disable field stays writable. Emulation modes freeze the whole register. Special modes allow every field to be rewritten at any time. Bus-control signals reach the pins only in expanded modes. The bus clock output works in every mode. When tagging is enabled, the low-strobe pin is shared: the bus drives the strobe during the low phase of the bus clock, and the block samples a low tag bit on each rising edge of that clock.

Mode encoding used throughout: 0 normal single-chip, 1 normal expanded narrow, 2 normal expanded wide, 3 emulation narrow, 4 emulation wide, 5 special single-chip, 6 special expanded, 7 special peripheral. Modes 0–2 are normal, 3–4 are emulation and 5–7 are special. Modes 1, 2, 3, 4 and 6 are expanded.

Register bits: 7 free-cycle enable, 5 queue-status enable (pins 6:5), 4 clock disable, 3 low-strobe enable, 2 read/write enable. Bits 6, 1 and 0 are unused. A 1 in an enable field selects the bus function. A 1 in the clock-disable field selects GPIO.

Top module: `pin_func_ctrl`

## Requirements
- R1: A write is sampled on a rising clock edge and is visible on `rd_data` after that edge. After a synchronous reset, `rd_data` reads 0xAC if `mode` was 3 or 4 during reset, and 0x00 otherwise.
- R2: In modes 0–2, the first write after reset loads bits 7, 5, 3 and 2. Every later write leaves those four bits unchanged.
- R3: In normal and special modes, every write loads bit 4 (clock disable), including writes made after the write-once fields have locked.
- R4: In modes 3 and 4, writes change no register bit.
- R5: In modes 5–7, every write loads all five fields.
- R6: Bits 6, 1 and 0 always read 0 and ignore written values.
- R7: When bit 4 is 0, in any mode, pin 4 is driven (`pin_oe[4]`=1). Its value is `bus_clk` if `clk_stretch`=0 and `bus_clk & ext_cycle` if `clk_stretch`=1. When bit 4 is 1, pin 4 follows `gpio_do[4]`/`gpio_oe[4]`.
- R8: In expanded modes, the following pins are driven with output enable 1 when their field is 1: bit 7 puts `free_cycle` on pin 7, bit 5 puts `queue_stat[1:0]` on pins 6:5, and bit 2 puts `rw_line` on pin 2. When the field is 0, those pins follow the GPIO path.
- R9: In modes 0, 5 and 7, bits 7, 5 and 2 have no effect, and pins 7:5 and 2 follow the GPIO path.
- R10: Bit 3 puts `lo_strobe` on pin 3 (output enable 1) in expanded modes other than mode 1. In modes 0, 1, 5 and 7, pin 3 follows the GPIO path.
- R11: While the low strobe is active and `tag_en`=1, `pin_oe[3]` equals the inverse of `bus_clk`. On the clock edge after `bus_clk` goes from 0 to 1 across two consecutive edges, `tag_lo` takes `tag_pin_i`. At other times `tag_lo` holds its value.
- R12: Pins 1:0 always follow `gpio_do[1:0]` and `gpio_oe[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Operating mode code |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read-back |
| bus_clk | input | 1 | External bus clock level |
| clk_stretch | input | 1 | 1: clock output only during external cycles |
| ext_cycle | input | 1 | External access in progress |
| free_cycle | input | 1 | CPU free-cycle indicator |
| queue_stat | input | 2 | Instruction-queue status |
| lo_strobe | input | 1 | Low-byte strobe from bus logic |
| rw_line | input | 1 | Read/write line from bus logic |
| tag_en | input | 1 | Tag mode enable |
| tag_pin_i | input | 1 | Level seen on pin 3 |
| tag_lo | output | 1 | Captured low tag bit |
| gpio_do | input | 8 | GPIO output data |
| gpio_oe | input | 8 | GPIO output enables |
| pin_do | output | 8 | Pin output data |
| pin_oe | output | 8 | Pin output enables |

## Verification
The bench targets the write-once lock. A design whose lock never sets lets a second write in a normal mode change bits 7, 5, 3 and 2. A design whose lock also covers the clock-disable bit freezes bit 4 and fails the check after locking. Emulation writes that get through, or a reset value taken from the wrong mode, show up directly on the read-back. The bench also checks the mode gating: single-chip, peripheral and narrow-normal modes must leave pins on the GPIO path, so a wrong expanded-mode decode moves a pin enable. In the tag-capture sequence, a design that samples on level rather than on the edge overwrites `tag_lo` while `bus_clk` stays high.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int REG_W   = 8;
    localparam int PORT_W  = 8;
    localparam int LOW_PINS = 2;

    // bit positions decoded by the read-back path
    localparam int B_FC = 7;
    localparam int B_QS = 5;
    localparam int B_CD = 4;
    localparam int B_LS = 3;
    localparam int B_RW = 2;

    localparam logic [REG_W-1:0] FIELD_MASK = 8'hBC;
    localparam logic [REG_W-1:0] EMUL_RESET = 8'hAC;

    typedef enum logic [2:0] {
        M_NSC = 3'd0,
        M_NXN = 3'd1,
        M_NXW = 3'd2,
        M_EXN = 3'd3,
        M_EXW = 3'd4,
        M_SSC = 3'd5,
        M_SXP = 3'd6,
        M_SPR = 3'd7
    } mode_e;

    typedef struct packed {
        logic fc;
        logic qs;
        logic cd;
        logic ls;
        logic rw;
    } ctl_t;

    // lock index order
    localparam int L_FC = 3;
    localparam int L_QS = 2;
    localparam int L_LS = 1;
    localparam int L_RW = 0;

    function automatic logic is_normal(mode_e m);
        return (m == M_NSC) || (m == M_NXN) || (m == M_NXW);
    endfunction

    function automatic logic is_emul(mode_e m);
        return (m == M_EXN) || (m == M_EXW);
    endfunction

    function automatic logic is_special(mode_e m);
        return (m == M_SSC) || (m == M_SXP) || (m == M_SPR);
    endfunction

    function automatic logic is_expanded(mode_e m);
        return (m == M_NXN) || (m == M_NXW) || (m == M_EXN) ||
               (m == M_EXW) || (m == M_SXP);
    endfunction

    function automatic logic [REG_W-1:0] ctl_to_byte(ctl_t c);
        logic [REG_W-1:0] b;
        b       = '0;
        b[B_FC] = c.fc;
        b[B_QS] = c.qs;
        b[B_CD] = c.cd;
        b[B_LS] = c.ls;
        b[B_RW] = c.rw;
        return b;
    endfunction

    function automatic ctl_t byte_to_ctl(logic [REG_W-1:0] b);
        ctl_t c;
        c.fc = b[B_FC];
        c.qs = b[B_QS];
        c.cd = b[B_CD];
        c.ls = b[B_LS];
        c.rw = b[B_RW];
        return c;
    endfunction

    function automatic ctl_t reset_ctl(mode_e m);
        return byte_to_ctl(is_emul(m) ? EMUL_RESET : '0);
    endfunction

endpackage

// File: rtl/pfc_regfile.sv
module pfc_regfile
    import pfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output ctl_t             ctl_o,
    output logic [REG_W-1:0] rd_data_o
);

    typedef struct packed {
        ctl_t       ctl;
        logic [3:0] lock;
    } rf_state_t;

    rf_state_t s_d, s_q;
    ctl_t      wr_ctl;
    logic      once_ok_fc, once_ok_qs, once_ok_ls, once_ok_rw;
    logic      any_ok_cd;
    logic      unused_wr_bits;

    assign wr_ctl         = byte_to_ctl(wr_data_i);
    assign unused_wr_bits = ^{wr_data_i[6], wr_data_i[1:0]};

    always_comb begin
        once_ok_fc = is_special(mode_i) || (is_normal(mode_i) && !s_q.lock[L_FC]);
        once_ok_qs = is_special(mode_i) || (is_normal(mode_i) && !s_q.lock[L_QS]);
        once_ok_ls = is_special(mode_i) || (is_normal(mode_i) && !s_q.lock[L_LS]);
        once_ok_rw = is_special(mode_i) || (is_normal(mode_i) && !s_q.lock[L_RW]);
        any_ok_cd  = is_special(mode_i) || is_normal(mode_i);

        s_d = s_q;
        if (!rst_n) begin
            s_d.ctl  = reset_ctl(mode_i);
            s_d.lock = '0;
        end else if (wr_en_i) begin
            if (once_ok_fc) s_d.ctl.fc = wr_ctl.fc;
            if (once_ok_qs) s_d.ctl.qs = wr_ctl.qs;
            if (once_ok_ls) s_d.ctl.ls = wr_ctl.ls;
            if (once_ok_rw) s_d.ctl.rw = wr_ctl.rw;
            if (any_ok_cd)  s_d.ctl.cd = wr_ctl.cd;
            if (is_normal(mode_i)) s_d.lock = '1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ctl_o     = s_q.ctl;
    assign rd_data_o = ctl_to_byte(s_q.ctl);

    p_emul_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && is_emul(mode_i)) |=> $stable(rd_data_o));

    p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && is_normal(mode_i) && (s_q.lock == 4'hF))
        |=> $stable({rd_data_o[B_FC], rd_data_o[B_QS], rd_data_o[B_LS], rd_data_o[B_RW]}));

    p_clk_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !is_emul(mode_i)) |=> (rd_data_o[B_CD] == $past(wr_data_i[B_CD])));

    p_special_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && is_special(mode_i)) |=> (rd_data_o == ($past(wr_data_i) & FIELD_MASK)));

endmodule

// File: rtl/pfc_tagcap.sv
module pfc_tagcap (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en_i,
    input  logic bus_clk_i,
    input  logic pin_i,
    output logic tag_o
);

    typedef struct packed {
        logic bclk_prev;
        logic tag;
    } tc_state_t;

    tc_state_t s_d, s_q;
    logic      rise;

    assign rise = bus_clk_i && !s_q.bclk_prev;

    always_comb begin
        s_d = s_q;
        if (!rst_n) begin
            s_d = '0;
        end else begin
            s_d.bclk_prev = bus_clk_i;
            if (cap_en_i && rise) s_d.tag = pin_i;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign tag_o = s_q.tag;

    p_tag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_en_i && rise) |=> $stable(tag_o));

    p_tag_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_i && rise) |=> (tag_o == $past(pin_i)));

endmodule

// File: rtl/pfc_pinmux.sv
module pfc_pinmux
    import pfc_pkg::*;
(
    input  mode_e             mode_i,
    input  ctl_t              ctl_i,
    input  logic              bus_clk_i,
    input  logic              stretch_i,
    input  logic              ext_cycle_i,
    input  logic              free_cycle_i,
    input  logic [1:0]        queue_i,
    input  logic              lo_strobe_i,
    input  logic              rw_i,
    input  logic              tag_en_i,
    input  logic [PORT_W-1:0] gpio_do_i,
    input  logic [PORT_W-1:0] gpio_oe_i,
    output logic [PORT_W-1:0] pin_do_o,
    output logic [PORT_W-1:0] pin_oe_o,
    output logic              ls_active_o
);

    localparam int HI_W = PORT_W - LOW_PINS;

    logic [PORT_W-1:LOW_PINS] hi_do, hi_oe;
    logic                     exp_mode;

    assign exp_mode    = is_expanded(mode_i);
    assign ls_active_o = ctl_i.ls && exp_mode && (mode_i != M_NXN);

    always_comb begin
        hi_do = gpio_do_i[PORT_W-1:LOW_PINS];
        hi_oe = gpio_oe_i[PORT_W-1:LOW_PINS];
        if (ctl_i.fc && exp_mode) begin
            hi_do[B_FC] = free_cycle_i;
            hi_oe[B_FC] = 1'b1;
        end
        if (ctl_i.qs && exp_mode) begin
            hi_do[B_QS+1:B_QS] = queue_i;
            hi_oe[B_QS+1:B_QS] = 2'b11;
        end
        if (!ctl_i.cd) begin
            hi_do[B_CD] = bus_clk_i && (!stretch_i || ext_cycle_i);
            hi_oe[B_CD] = 1'b1;
        end
        if (ls_active_o) begin
            hi_do[B_LS] = lo_strobe_i;
            hi_oe[B_LS] = tag_en_i ? !bus_clk_i : 1'b1;
        end
        if (ctl_i.rw && exp_mode) begin
            hi_do[B_RW] = rw_i;
            hi_oe[B_RW] = 1'b1;
        end
    end

    assign pin_do_o[PORT_W-1:LOW_PINS] = hi_do;
    assign pin_oe_o[PORT_W-1:LOW_PINS] = hi_oe;

    for (genvar i = 0; i < LOW_PINS; i++) begin : g_low
        assign pin_do_o[i] = gpio_do_i[i];
        assign pin_oe_o[i] = gpio_oe_i[i];
    end

    initial begin
        if (HI_W != 6) $error("pin map expects six controlled pins");
    end

endmodule

// File: rtl/pin_func_ctrl.sv
module pin_func_ctrl
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              bus_clk,
    input  logic              clk_stretch,
    input  logic              ext_cycle,
    input  logic              free_cycle,
    input  logic [1:0]        queue_stat,
    input  logic              lo_strobe,
    input  logic              rw_line,
    input  logic              tag_en,
    input  logic              tag_pin_i,
    output logic              tag_lo,
    input  logic [PORT_W-1:0] gpio_do,
    input  logic [PORT_W-1:0] gpio_oe,
    output logic [PORT_W-1:0] pin_do,
    output logic [PORT_W-1:0] pin_oe
);

    mode_e mode_m;
    ctl_t  ctl;
    logic  ls_active;

    assign mode_m = mode_e'(mode);

    pfc_regfile u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_m),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .ctl_o     (ctl),
        .rd_data_o (rd_data)
    );

    pfc_pinmux u_pinmux (
        .mode_i       (mode_m),
        .ctl_i        (ctl),
        .bus_clk_i    (bus_clk),
        .stretch_i    (clk_stretch),
        .ext_cycle_i  (ext_cycle),
        .free_cycle_i (free_cycle),
        .queue_i      (queue_stat),
        .lo_strobe_i  (lo_strobe),
        .rw_i         (rw_line),
        .tag_en_i     (tag_en),
        .gpio_do_i    (gpio_do),
        .gpio_oe_i    (gpio_oe),
        .pin_do_o     (pin_do),
        .pin_oe_o     (pin_oe),
        .ls_active_o  (ls_active)
    );

    pfc_tagcap u_tagcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en_i  (ls_active && tag_en),
        .bus_clk_i (bus_clk),
        .pin_i     (tag_pin_i),
        .tag_o     (tag_lo)
    );

    p_nonexp_gpio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_expanded(mode_m) |->
            ((pin_oe[7:5] == gpio_oe[7:5]) && (pin_oe[2] == gpio_oe[2]) &&
             (pin_do[7:5] == gpio_do[7:5]) && (pin_do[2] == gpio_do[2])));

    p_narrow_ls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_m == M_NXN) |-> ((pin_oe[3] == gpio_oe[3]) && (pin_do[3] == gpio_do[3])));

    p_low_pins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[1:0] == gpio_oe[1:0]) && (pin_do[1:0] == gpio_do[1:0]));

    p_clk_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[4] |-> pin_oe[4]);

endmodule

// File: tb/tb_pin_func_ctrl.sv
module tb_pin_func_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       bus_clk, clk_stretch, ext_cycle, free_cycle;
    logic [1:0] queue_stat;
    logic       lo_strobe, rw_line, tag_en, tag_pin_i, tag_lo;
    logic [7:0] gpio_do, gpio_oe, pin_do, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pin_func_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bus_clk(bus_clk), .clk_stretch(clk_stretch),
        .ext_cycle(ext_cycle), .free_cycle(free_cycle), .queue_stat(queue_stat),
        .lo_strobe(lo_strobe), .rw_line(rw_line), .tag_en(tag_en),
        .tag_pin_i(tag_pin_i), .tag_lo(tag_lo), .gpio_do(gpio_do),
        .gpio_oe(gpio_oe), .pin_do(pin_do), .pin_oe(pin_oe)
    );

    // {op(1: reset, 0: write), mode, data, expected read-back}
    localparam logic [19:0] VEC [15] = '{
        {1'b1, 3'd2, 8'h00, 8'h00},  // R1 normal wide reset
        {1'b0, 3'd2, 8'hFF, 8'hBC},  // R2 first write, R6 unused bits
        {1'b0, 3'd2, 8'h00, 8'hAC},  // R2 locked, R3 clock bit
        {1'b0, 3'd2, 8'h10, 8'hBC},  // R3
        {1'b1, 3'd4, 8'h00, 8'hAC},  // R1 emulation reset
        {1'b0, 3'd4, 8'h00, 8'hAC},  // R4
        {1'b0, 3'd4, 8'h10, 8'hAC},  // R4
        {1'b1, 3'd6, 8'h00, 8'h00},  // R1 special reset
        {1'b0, 3'd6, 8'hA4, 8'hA4},  // R5
        {1'b0, 3'd6, 8'h18, 8'h18},  // R5 rewrite
        {1'b0, 3'd6, 8'h43, 8'h00},  // R6
        {1'b1, 3'd0, 8'h00, 8'h00},  // R1
        {1'b0, 3'd0, 8'h04, 8'h04},  // R2 first write
        {1'b0, 3'd0, 8'h08, 8'h04},  // R2 ignored
        {1'b1, 3'd3, 8'h00, 8'hAC}   // R1 emulation narrow
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(logic [2:0] m);
        mode  = m;
        wr_en = 1'b0;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
    endtask

    task automatic do_write(logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode = 3'd2; wr_en = 1'b0; wr_data = '0;
        bus_clk = 1'b0; clk_stretch = 1'b0; ext_cycle = 1'b0; free_cycle = 1'b0;
        queue_stat = '0; lo_strobe = 1'b0; rw_line = 1'b0; tag_en = 1'b0;
        tag_pin_i = 1'b0; gpio_do = '0; gpio_oe = '0;
        @(negedge clk);

        // register access vectors (R1..R6)
        for (int i = 0; i < 15; i++) begin
            if (VEC[i][19]) do_reset(VEC[i][18:16]);
            else begin
                mode = VEC[i][18:16];
                do_write(VEC[i][15:8]);
            end
            chk($sformatf("R1-R6 vector %0d", i), rd_data, VEC[i][7:0]);
        end

        // R7 clock pin
        do_reset(3'd2);
        gpio_do = 8'h00; gpio_oe = 8'h00;
        bus_clk = 1'b1; clk_stretch = 1'b0; #1;
        chk("R7 clock oe", {7'd0, pin_oe[4]}, 8'd1);
        chk("R7 free-running", {7'd0, pin_do[4]}, 8'd1);
        clk_stretch = 1'b1; ext_cycle = 1'b0; #1;
        chk("R7 stretched idle", {7'd0, pin_do[4]}, 8'd0);
        ext_cycle = 1'b1; #1;
        chk("R7 stretched access", {7'd0, pin_do[4]}, 8'd1);
        do_write(8'h10);
        gpio_do = 8'h00; gpio_oe = 8'h00; #1;
        chk("R7 disabled gpio", {6'd0, pin_oe[4], pin_do[4]}, 8'd0);

        // R8 bus functions in expanded mode
        do_reset(3'd2);
        do_write(8'hA4);
        bus_clk = 1'b0; clk_stretch = 1'b0;
        free_cycle = 1'b1; queue_stat = 2'b10; rw_line = 1'b0;
        gpio_do = 8'h00; gpio_oe = 8'h00; #1;
        chk("R8 oe pins 7:5,2", {pin_oe[7:5], pin_oe[2]}, 8'h0F);
        chk("R8 data pins 7:5,2", {pin_do[7:5], pin_do[2]}, 8'h0C);
        rw_line = 1'b1; free_cycle = 1'b0; queue_stat = 2'b01; #1;
        chk("R8 data follow", {pin_do[7:5], pin_do[2]}, 8'h03);

        // R9 no effect outside expanded modes
        do_reset(3'd0);
        do_write(8'hAC);
        gpio_do = 8'hFF; gpio_oe = 8'h00; #1;
        chk("R9 single-chip oe", {pin_oe[7:5], pin_oe[2]}, 8'h00);
        chk("R9 single-chip data", {pin_do[7:5], pin_do[2]}, 8'h0F);
        do_reset(3'd7);
        do_write(8'hAC);
        gpio_do = 8'h00; gpio_oe = 8'h00; #1;
        chk("R9 peripheral oe", {pin_oe[7:5], pin_oe[3:2]}, 8'h00);

        // R10 low strobe gating
        do_reset(3'd1);
        do_write(8'h08);
        chk("R10 narrow readback", rd_data, 8'h08);
        lo_strobe = 1'b1; gpio_do = 8'h00; gpio_oe = 8'h00; #1;
        chk("R10 narrow stays gpio", {6'd0, pin_oe[3], pin_do[3]}, 8'h00);
        do_reset(3'd2);
        do_write(8'h08); #1;
        chk("R10 wide drives strobe", {6'd0, pin_oe[3], pin_do[3]}, 8'h03);

        // R11 tag mode
        do_reset(3'd6);
        do_write(8'h08);
        tag_en = 1'b1; bus_clk = 1'b0; #1;
        chk("R11 oe while bus clock low", {7'd0, pin_oe[3]}, 8'd1);
        bus_clk = 1'b1; #1;
        chk("R11 oe while bus clock high", {7'd0, pin_oe[3]}, 8'd0);
        bus_clk = 1'b0; tick();
        chk("R11 tag reset value", {7'd0, tag_lo}, 8'd0);
        tag_pin_i = 1'b1; bus_clk = 1'b1; tick();
        chk("R11 tag captured on rise", {7'd0, tag_lo}, 8'd1);
        tag_pin_i = 1'b0; tick();
        chk("R11 tag held while high", {7'd0, tag_lo}, 8'd1);
        tag_en = 1'b0;

        // R12 low pins pass through
        gpio_do = 8'h02; gpio_oe = 8'h01; #1;
        chk("R12 low pin data", {6'd0, pin_do[1:0]}, 8'h02);
        chk("R12 low pin oe", {6'd0, pin_oe[1:0]}, 8'h01);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule